// File: doc/BRIEF.md
# Frame Reject Signal Generator

This block sits beside an MII-style receive path and decides whether a frame that is still arriving gets flagged for rejection toward the MAC. A start-of-frame strobe, given in the clock where the start-of-frame delimiter is seen, restarts a bit-time counter. On a 4-bit MII each receive clock carries one nibble, so the counter advances by four bit times per clock. The filtering logic raises a reject request at any point. The block accepts that request only while the frame is inside a bounded window of bit times after the delimiter.

An accepted reject is held for the rest of the frame and is released when receive data-valid falls. It is presented on a reject pin whose active level comes from a configuration bit. It is also merged with the PHY's receive-error line onto a forced-error output, which always uses the active-high sense of the reject. A request that comes after the window has closed is dropped, and a sticky miss flag records it until the next frame starts.

Top module: `frame_reject_gen`

## Requirements
- R1: After a synchronous active-low reset held for at least two clocks, the reject pin is inactive, the forced-error output follows only the receive-error input, and the miss flag is 0.
- R2: A reject request in the first receive clock after the start strobe (0 bit times elapsed, fewer than the 2-bit-time minimum) is ignored: the reject pin stays inactive.
- R3: A reject request sampled when 4 to 512 bit times have elapsed (clocks 1 to 128 after the start strobe, 4 bit times per clock) makes the reject active on the next clock.
- R4: A reject request sampled when more than 512 bit times have elapsed is ignored, and the miss flag goes to 1 on the next clock.
- R5: Once active, the reject stays active while receive data-valid is high, even after the request is removed. It clears one clock after data-valid goes low.
- R6: With the polarity input at 0 the reject pin is high when the reject is active. With it at 1 (registered, taking effect one clock later) the pin is low when the reject is active and high when it is idle.
- R7: The forced-error output is 1 whenever the receive-error input is 1 or the active-high reject is active, whatever polarity is selected.
- R8: The miss flag holds its value until the next start strobe, which clears it together with any reject.
- R9: A reject request while no frame is in progress (data-valid low) has no effect on the reject or the miss flag.
- R10: Asserting reset in the middle of a frame clears an active reject and the miss flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| sfd_i | input | 1 | One-clock strobe at the start-of-frame delimiter |
| rx_dv_i | input | 1 | Receive data-valid for the current frame |
| rx_er_i | input | 1 | PHY receive-error line |
| rej_req_i | input | 1 | Reject request from the filtering logic |
| cfg_rej_low_i | input | 1 | Polarity select: 1 makes the reject pin active low |
| rej_o | output | 1 | Reject pin with the selected polarity |
| frx_er_o | output | 1 | Forced receive error: receive error OR active-high reject |
| late_miss_o | output | 1 | Sticky flag: a request came after the window closed |

## Verification
The hardest cases to reach are the two edges of the window: the last clock that still accepts a request (512 bit times) and the first clock that drops one (516 bit times). The stimulus raises data-valid and the start strobe together, counts an exact number of receive clocks, and then pulses the request for one clock, so the elapsed bit time at sampling is known exactly. The same counted approach hits the first clock after the strobe (too early) and the first clock inside the window. Reset is also asserted in the middle of a held reject to show it clears.

// File: rtl/frj_pkg.sv
package frj_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE   = 2'd0,
        WIN_EARLY  = 2'd1,
        WIN_OPEN   = 2'd2,
        WIN_CLOSED = 2'd3
    } win_e;

endpackage

// File: rtl/frj_bit_timer.sv
module frj_bit_timer
    import frj_pkg::*;
#(
    parameter int MIN_BITS     = 2,
    parameter int MAX_BITS     = 512,
    parameter int BITS_PER_CLK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sfd_i,
    input  logic rx_dv_i,
    output win_e phase_o
);
    localparam int CW = $clog2(MAX_BITS + 2 * BITS_PER_CLK + 1);

    typedef struct packed {
        logic          in_frame;
        logic [CW-1:0] bits;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sfd_i) begin
            st_d.in_frame = 1'b1;
            st_d.bits     = '0;
        end else if (!rx_dv_i) begin
            st_d.in_frame = 1'b0;
            st_d.bits     = '0;
        end else if (st_q.in_frame && (int'(st_q.bits) <= MAX_BITS)) begin
            st_d.bits = st_q.bits + CW'(BITS_PER_CLK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!st_q.in_frame)                    phase_o = WIN_IDLE;
        else if (int'(st_q.bits) < MIN_BITS)   phase_o = WIN_EARLY;
        else if (int'(st_q.bits) <= MAX_BITS)  phase_o = WIN_OPEN;
        else                                   phase_o = WIN_CLOSED;
    end

endmodule

// File: rtl/frj_reject_ctl.sv
module frj_reject_ctl
    import frj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sfd_i,
    input  logic rx_dv_i,
    input  logic rej_req_i,
    input  win_e phase_i,
    output logic rej_act_o,
    output logic miss_o
);
    typedef struct packed {
        logic rej;
        logic miss;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sfd_i) begin
            st_d.rej  = 1'b0;
            st_d.miss = 1'b0;
        end else if (!rx_dv_i) begin
            st_d.rej = 1'b0;
        end else if (rej_req_i && phase_i == WIN_OPEN) begin
            st_d.rej = 1'b1;
        end else if (rej_req_i && phase_i == WIN_CLOSED && !st_q.rej) begin
            st_d.miss = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rej_act_o = st_q.rej;
    assign miss_o    = st_q.miss;

endmodule

// File: rtl/frj_out_stage.sv
module frj_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_rej_low_i,
    input  logic rx_er_i,
    input  logic rej_act_i,
    output logic rej_o,
    output logic frx_er_o
);
    typedef struct packed {
        logic active_low;
    } pol_t;

    pol_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.active_low = cfg_rej_low_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rej_o    = rej_act_i ^ st_q.active_low;
    assign frx_er_o = rx_er_i | rej_act_i;

endmodule

// File: rtl/frame_reject_gen.sv
module frame_reject_gen
    import frj_pkg::*;
#(
    parameter int MIN_BITS     = 2,
    parameter int MAX_BITS     = 512,
    parameter int BITS_PER_CLK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sfd_i,
    input  logic rx_dv_i,
    input  logic rx_er_i,
    input  logic rej_req_i,
    input  logic cfg_rej_low_i,
    output logic rej_o,
    output logic frx_er_o,
    output logic late_miss_o
);
    win_e phase;
    logic rej_act;

    frj_bit_timer #(
        .MIN_BITS     (MIN_BITS),
        .MAX_BITS     (MAX_BITS),
        .BITS_PER_CLK (BITS_PER_CLK)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sfd_i   (sfd_i),
        .rx_dv_i (rx_dv_i),
        .phase_o (phase)
    );

    frj_reject_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfd_i     (sfd_i),
        .rx_dv_i   (rx_dv_i),
        .rej_req_i (rej_req_i),
        .phase_i   (phase),
        .rej_act_o (rej_act),
        .miss_o    (late_miss_o)
    );

    frj_out_stage u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_rej_low_i (cfg_rej_low_i),
        .rx_er_i       (rx_er_i),
        .rej_act_i     (rej_act),
        .rej_o         (rej_o),
        .frx_er_o      (frx_er_o)
    );

endmodule

// File: rtl/frame_reject_gen_checker.sv
module frame_reject_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic sfd_i,
    input logic rx_dv_i,
    input logic rej_req_i,
    input logic rej_act,
    input logic frx_er_o,
    input logic late_miss_o
);
    // R3: a reject only starts in response to a request
    a_r3_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rej_act) |-> $past(rej_req_i));

    // R4: the miss flag only sets in response to a request
    a_r4_miss_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_miss_o) |-> $past(rej_req_i));

    // R5: an active reject is held through the frame
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_act && rx_dv_i && !sfd_i) |=> rej_act);

    // R5: the reject is released once data-valid is low
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dv_i && !sfd_i) |=> !rej_act);

    // R7: the forced-error output covers an active reject
    a_r7_frx_covers: assert property (@(posedge clk) disable iff (!rst_n)
        rej_act |-> frx_er_o);

    // R8: the start strobe clears the miss flag
    a_r8_sfd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sfd_i |=> !late_miss_o);
endmodule

bind frame_reject_gen frame_reject_gen_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfd_i       (sfd_i),
    .rx_dv_i     (rx_dv_i),
    .rej_req_i   (rej_req_i),
    .rej_act     (rej_act),
    .frx_er_o    (frx_er_o),
    .late_miss_o (late_miss_o)
);

// File: tb/frame_reject_gen_bench.sv
module frame_reject_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sfd = 1'b0, rx_dv = 1'b0, rx_er = 1'b0, req = 1'b0, pol = 1'b0;
    logic rej, frx, miss;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_reject_gen u_frame_reject_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .sfd_i         (sfd),
        .rx_dv_i       (rx_dv),
        .rx_er_i       (rx_er),
        .rej_req_i     (req),
        .cfg_rej_low_i (pol),
        .rej_o         (rej),
        .frx_er_o      (frx),
        .late_miss_o   (miss)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sfd = 0; rx_dv = 0; rx_er = 0; req = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    // start a frame, wait m clocks so 4*m bit times have elapsed, pulse request
    task automatic frame_req(int m);
        rx_dv = 1'b1; sfd = 1'b1;
        tick(1);
        sfd = 1'b0;
        tick(m);
        req = 1'b1;
        tick(1);
        req = 1'b0;
    endtask

    task automatic end_frame();
        rx_dv = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        pol = 0;
        do_reset();
        check("R1 reject idle", rej, 1'b0);
        check("R1 frx idle", frx, 1'b0);
        check("R1 miss clear", miss, 1'b0);
        rx_er = 1'b1; tick(1);
        check("R1 frx follows rx_er", frx, 1'b1);
        rx_er = 1'b0; tick(1);
    endtask

    task automatic t_early();
        frame_req(0);
        check("R2 early request ignored", rej, 1'b0);
        check("R2 early no miss", miss, 1'b0);
        end_frame();
    endtask

    task automatic t_first_open();
        frame_req(1);
        check("R3 request at 4 bits honoured", rej, 1'b1);
        check("R7 frx with reject", frx, 1'b1);
        end_frame();
        check("R5 cleared after dv low", rej, 1'b0);
    endtask

    task automatic t_last_open();
        frame_req(128);
        check("R3 request at 512 bits honoured", rej, 1'b1);
        check("R3 no miss at 512", miss, 1'b0);
        tick(5);
        check("R5 held after request removed", rej, 1'b1);
        end_frame();
        check("R5 released", rej, 1'b0);
    endtask

    task automatic t_late();
        frame_req(129);
        check("R4 request at 516 bits ignored", rej, 1'b0);
        check("R4 miss set", miss, 1'b1);
        end_frame();
        check("R8 miss held after frame", miss, 1'b1);
        rx_dv = 1'b1; sfd = 1'b1; tick(1); sfd = 1'b0;
        check("R8 miss cleared by start strobe", miss, 1'b0);
        end_frame();
    endtask

    task automatic t_idle_req();
        req = 1'b1; tick(3); req = 1'b0;
        check("R9 idle request no reject", rej, 1'b0);
        check("R9 idle request no miss", miss, 1'b0);
        check("R9 frx quiet", frx, 1'b0);
    endtask

    task automatic t_polarity();
        pol = 1'b1; tick(1);
        check("R6 active-low idle high", rej, 1'b1);
        check("R7 frx idle under active-low", frx, 1'b0);
        frame_req(10);
        check("R6 active-low asserted low", rej, 1'b0);
        check("R7 frx uses logical reject", frx, 1'b1);
        end_frame();
        check("R6 active-low released high", rej, 1'b1);
        pol = 1'b0; tick(1);
        check("R6 back to active-high idle", rej, 1'b0);
    endtask

    task automatic t_rx_er();
        rx_dv = 1'b1; sfd = 1'b1; tick(1); sfd = 1'b0;
        rx_er = 1'b1; tick(1);
        check("R7 frx from rx_er alone", frx, 1'b1);
        check("R7 rx_er no reject", rej, 1'b0);
        rx_er = 1'b0; tick(1);
        check("R7 frx drops", frx, 1'b0);
        end_frame();
    endtask

    task automatic t_reset_mid();
        frame_req(5);
        check("R10 pre reset active", rej, 1'b1);
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(1);
        check("R10 reject cleared by reset", rej, 1'b0);
        check("R10 miss clear", miss, 1'b0);
        end_frame();
    endtask

    initial begin
        tick(1);
        t_reset();
        t_early();
        t_first_open();
        t_last_open();
        t_late();
        t_idle_req();
        t_polarity();
        t_rx_er();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule